// File: doc/BRIEF.md
# SMBus Block Transaction Engine

This block is the byte-level protocol side of an SMBus/I2C slave that fronts a bank of configuration registers and non-volatile memory. It oversamples the SCL and SDA lines on the system clock, finds START and STOP conditions, shifts bits in and out, answers its configured 7-bit address, and decodes four kinds of transaction. A send byte loads the address pointer. A block write takes command 83h and a byte count of 1 to 16, then stores that many data bytes. A receive byte returns the byte at the pointer. A block read takes command 84h, then a repeated START with a read address, and returns a count byte of 16 followed by up to 16 data bytes.

The block does not hold the pointer or the storage itself. It issues pointer-load, write and pointer-advance strobes to a separate storage unit, and it reads that unit's current byte on `rd_data_i`. The open-drain SDA pad is modelled by `sda_oe`. When `sda_oe` is high the block pulls SDA low, and when it is low SDA is released. An acknowledge is SDA low in the ninth clock of a byte. All bytes travel MSB first, and an address byte carries the 7-bit address in bits 7:1 with bit 0 set to 1 for a read.

Top module: `smb_block_engine`

## Requirements
- R1: During and right after reset `sda_oe`, `ptr_load_o`, `wr_stb_o` and `ptr_inc_o` are all 0. Apart from the release on a START or STOP, the block changes `sda_oe` only while SCL is low.
- R2: After a matching write address, a command byte in the range 00h to 45h is acknowledged and loads the pointer with that value through `ptr_load_o`/`ptr_val_o`. A command above 45h other than 83h and 84h is not acknowledged and loads nothing.
- R3: Command 83h followed by a count N of 1 to 16 acknowledges the command, the count and each of the N data bytes. Every data byte gives one `wr_stb_o` pulse carrying the byte on `wr_data_o`, with `ptr_inc_o` in the same cycle, so the bytes land at successive pointer values in the order they were sent.
- R4: A block write count of 0 or greater than 16 is not acknowledged, and no data byte that follows it is acknowledged or written.
- R5: Data bytes beyond the announced block write count are not acknowledged and cause no write.
- R6: A read address that does not follow an accepted 84h command is a receive byte. The block sends the byte at the pointer and advances the pointer once for each byte sent, whether or not the master acknowledges it. It keeps sending successive bytes while the master acknowledges.
- R7: Command 84h is acknowledged and arms a block read. A repeated START with a matching read address then returns a count byte of 10h followed by the bytes at successive pointer values, at most 16 of them. The pointer advances once per data byte, and after the 16th data byte SDA stays released.
- R8: After a master NACK on a byte the block sends, the block releases SDA and sends and advances nothing more. A STOP releases SDA in the following cycle.
- R9: If `busy_i` is high when command 84h is received, the command is not acknowledged and no block read is armed, so a following read behaves as a receive byte.
- R10: An address byte whose bits 7:1 differ from `dev_addr` is not acknowledged. SDA is never driven and no strobe is issued until the next START.
- R11: A START or STOP arriving before the eighth bit of a byte abandons that byte without any write. After a START the block expects a fresh address byte.
- R12: A STOP disarms a pending block read, so a read after a later START is a receive byte.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock that oversamples SCL and SDA |
| rst_n | input | 1 | Synchronous active-low reset |
| scl_i | input | 1 | SCL line level |
| sda_i | input | 1 | SDA line level |
| sda_oe | output | 1 | 1 pulls SDA low, 0 releases it |
| dev_addr | input | 7 | Configured slave address |
| busy_i | input | 1 | Storage busy; withholds the acknowledge of 84h |
| rd_data_i | input | 8 | Byte at the storage unit's current pointer |
| ptr_load_o | output | 1 | One-cycle pulse: load pointer with `ptr_val_o` |
| ptr_val_o | output | 8 | New pointer value |
| wr_stb_o | output | 1 | One-cycle pulse: write `wr_data_o` at the pointer |
| wr_data_o | output | 8 | Byte to write |
| ptr_inc_o | output | 1 | One-cycle pulse: advance the pointer by one |

## Verification
In a block write the write strobe and the pointer-advance strobe fire in the same cycle. The storage unit has to store at the old pointer before it moves on, so if the two drifted apart by a cycle, or came out in the wrong order, bytes would land one address off. The bench provokes this with random-length block writes at random pointers and reads the data back with block reads. It judges the result by comparing each byte and the final pointer against a model held in the bench. The same read-back also covers the second overlap: the pointer advance after a sent byte and the fetch of the next byte to send.

// File: rtl/smb_pkg.sv
// Package: shared types for the SMBus block transaction engine.
// Assumes: nothing beyond IEEE 1800-2017.
package smb_pkg;

    // Transaction-level state of the controller.
    typedef enum logic [2:0] {
        ST_IDLE,    // no transaction since STOP or reset
        ST_ADDR,    // expecting the address byte
        ST_CMD,     // expecting the command byte of a write
        ST_CNT,     // expecting the block write count
        ST_WDATA,   // receiving block write data
        ST_RD,      // transmitting to the master
        ST_SKIP     // rest of the transaction is NACKed / released
    } txn_st_t;

endpackage

// File: rtl/smb_line_sync.sv
// Module: smb_line_sync
// Synchronises SCL and SDA into the clock domain and reports SCL edges
// and START/STOP conditions as one-cycle pulses.
// Assumes: the clock runs at least ~8x faster than SCL; lines idle high.
module smb_line_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic scl_s,
    output logic sda_s,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_det,
    output logic stop_det
);

    logic [STAGES-1:0] scl_sh;
    logic [STAGES-1:0] sda_sh;
    logic              scl_q;
    logic              sda_q;

    // Purpose: shift raw lines through the synchroniser and keep last level.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            scl_sh <= '1;
            sda_sh <= '1;
            scl_q  <= 1'b1;
            sda_q  <= 1'b1;
        end else begin
            scl_sh <= {scl_sh[STAGES-2:0], scl_i};
            sda_sh <= {sda_sh[STAGES-2:0], sda_i};
            scl_q  <= scl_sh[STAGES-1];
            sda_q  <= sda_sh[STAGES-1];
        end
    end

    // Purpose: derive edge and bus-condition pulses from two samples.
    always_comb begin
        scl_s     = scl_sh[STAGES-1];
        sda_s     = sda_sh[STAGES-1];
        scl_rise  = scl_s & ~scl_q;
        scl_fall  = ~scl_s & scl_q;
        start_det = scl_s & scl_q & sda_q & ~sda_s;
        stop_det  = scl_s & scl_q & ~sda_q & sda_s;
    end

endmodule

// File: rtl/smb_bit_link.sv
// Module: smb_bit_link
// Bit-level framing: counts the DW data bits and the acknowledge slot
// of each byte, assembles received bytes, serialises transmit bytes
// MSB first and drives the acknowledge the controller asks for.
// Assumes: SCL edges and START/STOP come from smb_line_sync; the
// controller settles ack_req, tx_next and tx_byte before the SCL fall
// that uses them.
module smb_bit_link #(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          scl_rise,
    input  logic          scl_fall,
    input  logic          start_det,
    input  logic          stop_det,
    input  logic          sda_s,
    input  logic          ack_req,
    input  logic          tx_next,
    input  logic [DW-1:0] tx_byte,
    output logic          rx_done,
    output logic [DW-1:0] rx_byte,
    output logic          slot_rise,
    output logic          slot_tx,
    output logic          mst_ack,
    output logic          sda_oe
);

    localparam int CW = $clog2(DW + 2);
    localparam logic [CW-1:0] LASTB = CW'(DW - 1);
    localparam logic [CW-1:0] SLOT  = CW'(DW);
    localparam logic [CW-1:0] ENDC  = CW'(DW + 1);

    logic          active;
    logic [CW-1:0] bitcnt;
    logic [DW-1:0] rx_sh;
    logic [DW-1:0] tx_sh;
    logic          tx_frm;

    // Purpose: frame counter, shifters and SDA drive, restarted on START/STOP.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active    <= 1'b0;
            bitcnt    <= '0;
            rx_sh     <= '0;
            tx_sh     <= '0;
            tx_frm    <= 1'b0;
            sda_oe    <= 1'b0;
            rx_done   <= 1'b0;
            rx_byte   <= '0;
            slot_rise <= 1'b0;
            slot_tx   <= 1'b0;
            mst_ack   <= 1'b0;
        end else begin
            rx_done   <= 1'b0;
            slot_rise <= 1'b0;
            if (start_det || stop_det) begin
                active <= start_det;
                bitcnt <= '0;
                tx_frm <= 1'b0;
                sda_oe <= 1'b0;
            end else if (active) begin
                if (scl_rise) begin
                    if (bitcnt < SLOT) begin
                        rx_sh <= {rx_sh[DW-2:0], sda_s};
                        if (bitcnt == LASTB && !tx_frm) begin
                            rx_done <= 1'b1;
                            rx_byte <= {rx_sh[DW-2:0], sda_s};
                        end
                    end else if (bitcnt == SLOT) begin
                        slot_rise <= 1'b1;
                        slot_tx   <= tx_frm;
                        mst_ack   <= ~sda_s;
                    end
                    if (bitcnt < ENDC) begin
                        bitcnt <= bitcnt + 1'b1;
                    end
                end else if (scl_fall) begin
                    if (bitcnt == SLOT) begin
                        sda_oe <= tx_frm ? 1'b0 : ack_req;
                    end else if (bitcnt == ENDC) begin
                        bitcnt <= '0;
                        tx_frm <= tx_next;
                        tx_sh  <= tx_byte;
                        sda_oe <= tx_next & ~tx_byte[DW-1];
                    end else if (tx_frm && bitcnt != '0) begin
                        tx_sh  <= {tx_sh[DW-2:0], 1'b0};
                        sda_oe <= ~tx_sh[DW-2];
                    end
                end
            end
        end
    end

    // R8: a STOP always leaves SDA released in the next cycle.
    a_r8_release_on_stop: assert property (@(posedge clk) disable iff (!rst_n)
        stop_det |=> !sda_oe);

endmodule

// File: rtl/smb_txn_ctrl.sv
// Module: smb_txn_ctrl
// Transaction controller: matches the address, decodes the command,
// runs block write, receive byte and block read, decides every ACK,
// and issues pointer-load, write and pointer-advance strobes.
// Assumes: DW == AW + 1; rd_data reflects the storage pointer one
// cycle after a strobe; byte events arrive from smb_bit_link.
module smb_txn_ctrl
    import smb_pkg::*;
#(
    parameter int            AW      = 7,
    parameter int            DW      = 8,
    parameter int            BLK_MAX = 16,
    parameter logic [DW-1:0] MAX_PTR = 8'h45,
    parameter logic [DW-1:0] CMD_WR  = 8'h83,
    parameter logic [DW-1:0] CMD_RD  = 8'h84
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start_det,
    input  logic          stop_det,
    input  logic          rx_done,
    input  logic [DW-1:0] rx_byte,
    input  logic          slot_rise,
    input  logic          slot_tx,
    input  logic          mst_ack,
    input  logic [AW-1:0] dev_addr,
    input  logic          busy_i,
    input  logic [DW-1:0] rd_data,
    output logic          ack_req,
    output logic          tx_next,
    output logic [DW-1:0] tx_byte,
    output logic          selected,
    output logic          ptr_load,
    output logic [DW-1:0] ptr_val,
    output logic          wr_stb,
    output logic [DW-1:0] wr_data,
    output logic          ptr_inc
);

    localparam int LW = $clog2(BLK_MAX + 1);
    localparam logic [LW-1:0] BLK_N = LW'(BLK_MAX);

    txn_st_t       state;
    logic          armed;
    logic          cnt_phase;
    logic          is_blk;
    logic [LW-1:0] left;

    // Purpose: transmit while in the read state; count byte before data.
    always_comb begin
        tx_next = (state == ST_RD);
        tx_byte = cnt_phase ? DW'(BLK_MAX) : rd_data;
    end

    // Purpose: transaction sequencing, ACK decisions and storage strobes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= ST_IDLE;
            armed     <= 1'b0;
            cnt_phase <= 1'b0;
            is_blk    <= 1'b0;
            left      <= '0;
            ack_req   <= 1'b0;
            selected  <= 1'b0;
            ptr_load  <= 1'b0;
            ptr_val   <= '0;
            wr_stb    <= 1'b0;
            wr_data   <= '0;
            ptr_inc   <= 1'b0;
        end else begin
            ptr_load <= 1'b0;
            wr_stb   <= 1'b0;
            ptr_inc  <= 1'b0;
            if (stop_det) begin
                state     <= ST_IDLE;
                armed     <= 1'b0;
                cnt_phase <= 1'b0;
                ack_req   <= 1'b0;
                selected  <= 1'b0;
            end else if (start_det) begin
                state     <= ST_ADDR;
                cnt_phase <= 1'b0;
                ack_req   <= 1'b0;
                selected  <= 1'b0;
            end else if (rx_done) begin
                case (state)
                    ST_ADDR: begin
                        if (rx_byte[DW-1:1] == dev_addr) begin
                            selected <= 1'b1;
                            ack_req  <= 1'b1;
                            armed    <= 1'b0;
                            if (rx_byte[0]) begin
                                state     <= ST_RD;
                                is_blk    <= armed;
                                cnt_phase <= armed;
                                left      <= BLK_N;
                            end else begin
                                state <= ST_CMD;
                            end
                        end else begin
                            state   <= ST_SKIP;
                            ack_req <= 1'b0;
                        end
                    end
                    ST_CMD: begin
                        if (rx_byte == CMD_WR) begin
                            ack_req <= 1'b1;
                            state   <= ST_CNT;
                        end else if (rx_byte == CMD_RD) begin
                            ack_req <= ~busy_i;
                            armed   <= ~busy_i;
                            state   <= ST_SKIP;
                        end else if (rx_byte <= MAX_PTR) begin
                            ack_req  <= 1'b1;
                            ptr_load <= 1'b1;
                            ptr_val  <= rx_byte;
                            state    <= ST_SKIP;
                        end else begin
                            ack_req <= 1'b0;
                            state   <= ST_SKIP;
                        end
                    end
                    ST_CNT: begin
                        if (rx_byte != '0 && rx_byte <= DW'(BLK_MAX)) begin
                            ack_req <= 1'b1;
                            left    <= rx_byte[LW-1:0];
                            state   <= ST_WDATA;
                        end else begin
                            ack_req <= 1'b0;
                            state   <= ST_SKIP;
                        end
                    end
                    ST_WDATA: begin
                        if (left != '0) begin
                            ack_req <= 1'b1;
                            wr_stb  <= 1'b1;
                            ptr_inc <= 1'b1;
                            wr_data <= rx_byte;
                            left    <= left - 1'b1;
                        end else begin
                            ack_req <= 1'b0;
                        end
                    end
                    default: ack_req <= 1'b0;
                endcase
            end else if (slot_rise) begin
                ack_req <= 1'b0;
                if (state == ST_RD && slot_tx) begin
                    if (cnt_phase) begin
                        cnt_phase <= 1'b0;
                        if (!mst_ack) begin
                            state <= ST_SKIP;
                        end
                    end else begin
                        ptr_inc <= 1'b1;
                        if (is_blk) begin
                            left <= left - 1'b1;
                        end
                        if (!mst_ack || (is_blk && left == LW'(1))) begin
                            state <= ST_SKIP;
                        end
                    end
                end
            end
        end
    end

    // Checker state: writes issued against the count accepted for this transfer.
    logic [LW-1:0] chk_allow;
    logic [LW-1:0] chk_done;

    // Purpose: track the accepted block count and writes issued (assertion only).
    always_ff @(posedge clk) begin
        if (!rst_n || start_det) begin
            chk_allow <= '0;
            chk_done  <= '0;
        end else begin
            if (rx_done && state == ST_CNT) begin
                chk_allow <= rx_byte[LW-1:0];
            end
            if (wr_stb) begin
                chk_done <= chk_done + 1'b1;
            end
        end
    end

    // R5: never more writes than the announced count.
    a_r5_no_excess_write: assert property (@(posedge clk) disable iff (!rst_n)
        wr_stb |-> (chk_done < chk_allow));

    // R2: a pointer load never carries a value outside the register range.
    a_r2_ptr_in_range: assert property (@(posedge clk) disable iff (!rst_n)
        ptr_load |-> (ptr_val <= MAX_PTR && !wr_stb));

endmodule

// File: rtl/smb_block_engine.sv
// Module: smb_block_engine (top)
// SMBus slave block transaction engine: line synchroniser, bit link
// and transaction controller. Drives strobes toward an external
// pointer/storage unit and SDA through an open-drain enable.
// Assumes: clk oversamples SCL well above 8x; storage answers rd_data_i
// for its current pointer and applies a write before an advance.
module smb_block_engine #(
    parameter int            AW      = 7,
    parameter int            DW      = 8,
    parameter int            BLK_MAX = 16,
    parameter int            STAGES  = 2,
    parameter logic [DW-1:0] MAX_PTR = 8'h45,
    parameter logic [DW-1:0] CMD_WR  = 8'h83,
    parameter logic [DW-1:0] CMD_RD  = 8'h84
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          scl_i,
    input  logic          sda_i,
    output logic          sda_oe,
    input  logic [AW-1:0] dev_addr,
    input  logic          busy_i,
    input  logic [DW-1:0] rd_data_i,
    output logic          ptr_load_o,
    output logic [DW-1:0] ptr_val_o,
    output logic          wr_stb_o,
    output logic [DW-1:0] wr_data_o,
    output logic          ptr_inc_o
);

    logic          scl_s, sda_s, scl_rise, scl_fall, start_det, stop_det;
    logic          rx_done, slot_rise, slot_tx, mst_ack;
    logic [DW-1:0] rx_byte, tx_byte;
    logic          ack_req, tx_next, selected;

    smb_line_sync #(.STAGES(STAGES)) u_sync (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_i     (scl_i),
        .sda_i     (sda_i),
        .scl_s     (scl_s),
        .sda_s     (sda_s),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .start_det (start_det),
        .stop_det  (stop_det)
    );

    smb_bit_link #(.DW(DW)) u_link (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .start_det (start_det),
        .stop_det  (stop_det),
        .sda_s     (sda_s),
        .ack_req   (ack_req),
        .tx_next   (tx_next),
        .tx_byte   (tx_byte),
        .rx_done   (rx_done),
        .rx_byte   (rx_byte),
        .slot_rise (slot_rise),
        .slot_tx   (slot_tx),
        .mst_ack   (mst_ack),
        .sda_oe    (sda_oe)
    );

    smb_txn_ctrl #(
        .AW(AW), .DW(DW), .BLK_MAX(BLK_MAX),
        .MAX_PTR(MAX_PTR), .CMD_WR(CMD_WR), .CMD_RD(CMD_RD)
    ) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .start_det (start_det),
        .stop_det  (stop_det),
        .rx_done   (rx_done),
        .rx_byte   (rx_byte),
        .slot_rise (slot_rise),
        .slot_tx   (slot_tx),
        .mst_ack   (mst_ack),
        .dev_addr  (dev_addr),
        .busy_i    (busy_i),
        .rd_data   (rd_data_i),
        .ack_req   (ack_req),
        .tx_next   (tx_next),
        .tx_byte   (tx_byte),
        .selected  (selected),
        .ptr_load  (ptr_load_o),
        .ptr_val   (ptr_val_o),
        .wr_stb    (wr_stb_o),
        .wr_data   (wr_data_o),
        .ptr_inc   (ptr_inc_o)
    );

    // R10: SDA is only pulled while the block has been addressed.
    a_r10_drive_needs_match: assert property (@(posedge clk) disable iff (!rst_n)
        sda_oe |-> selected);

    // R1: SDA drive changes only after SCL went low, except START/STOP release.
    a_r1_sda_moves_scl_low: assert property (@(posedge clk) disable iff (!rst_n)
        (!$stable(sda_oe) && !$past(start_det || stop_det)) |-> !$past(scl_s));

endmodule

// File: tb/smb_block_engine_test.sv
module smb_block_engine_test;

    localparam logic [6:0] DEV = 7'h52;
    localparam int Q = 5;

    logic       clk = 1'b0;
    logic       rst_n;
    logic       scl;
    logic       m_sda;
    logic       busy;
    logic       sda_oe;
    logic       sda_line;
    logic [7:0] rd_data;
    logic       ptr_load, wr_stb, ptr_inc;
    logic [7:0] ptr_val, wr_data;

    logic [7:0] mem [256];
    logic [7:0] exp_mem [256];
    logic [7:0] sptr;
    logic [7:0] exp_ptr;

    int vecs = 0;
    int errs = 0;
    bit done = 0;
    bit watch = 0;
    int drove = 0;

    always #4 clk = ~clk;

    assign sda_line = m_sda & ~sda_oe;
    assign rd_data  = mem[sptr];

    smb_block_engine uut (
        .clk        (clk),
        .rst_n      (rst_n),
        .scl_i      (scl),
        .sda_i      (sda_line),
        .sda_oe     (sda_oe),
        .dev_addr   (DEV),
        .busy_i     (busy),
        .rd_data_i  (rd_data),
        .ptr_load_o (ptr_load),
        .ptr_val_o  (ptr_val),
        .wr_stb_o   (wr_stb),
        .wr_data_o  (wr_data),
        .ptr_inc_o  (ptr_inc)
    );

    function automatic logic [7:0] init_val(int i);
        return 8'((i * 37 + 5) ^ (i >> 3));
    endfunction

    // Storage unit model: write at pointer, then advance.
    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < 256; i++) mem[i] <= init_val(i);
            sptr <= 8'h00;
        end else if (ptr_load) begin
            sptr <= ptr_val;
        end else begin
            if (wr_stb) mem[sptr] <= wr_data;
            if (ptr_inc) sptr <= sptr + 8'd1;
        end
    end

    always @(posedge clk) if (watch && sda_oe) drove++;

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        vecs++;
        if (!ok) begin
            errs++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic qw();
        repeat (Q) @(negedge clk);
    endtask

    task automatic bus_start();
        m_sda = 1'b1; qw(); scl = 1'b1; qw(); m_sda = 1'b0; qw(); scl = 1'b0; qw();
    endtask

    task automatic bus_stop();
        m_sda = 1'b0; qw(); scl = 1'b1; qw(); m_sda = 1'b1; qw(); qw();
    endtask

    task automatic bus_bit(input logic b, output logic r);
        qw(); m_sda = b; qw(); scl = 1'b1; qw(); r = sda_line; qw(); scl = 1'b0;
    endtask

    task automatic wr_byte(input logic [7:0] b, output logic ack);
        logic r;
        for (int i = 7; i >= 0; i--) bus_bit(b[i], r);
        bus_bit(1'b1, r);
        ack = ~r;
    endtask

    task automatic rd_byte(output logic [7:0] b, input logic m_ack);
        logic r;
        for (int i = 7; i >= 0; i--) begin
            bus_bit(1'b1, r);
            b[i] = r;
        end
        bus_bit(~m_ack, r);
    endtask

    task automatic set_ptr(input logic [7:0] p, input bit expect_ack);
        logic a;
        bus_start();
        wr_byte({DEV, 1'b0}, a); chk(a, "R2", a, 1);
        wr_byte(p, a);           chk(a == expect_ack, "R2", a, expect_ack);
        bus_stop();
        if (expect_ack) exp_ptr = p;
        chk(sptr == exp_ptr, "R2", sptr, exp_ptr);
    endtask

    task automatic blk_write(input int n, input int extra);
        logic a;
        logic [7:0] d;
        int bad = 0;
        bus_start();
        wr_byte({DEV, 1'b0}, a); if (!a) bad++;
        wr_byte(8'h83, a);       if (!a) bad++;
        wr_byte(8'(n), a);       if (!a) bad++;
        for (int i = 0; i < n; i++) begin
            d = 8'($urandom);
            wr_byte(d, a); if (!a) bad++;
            exp_mem[exp_ptr] = d;
            exp_ptr = exp_ptr + 8'd1;
        end
        for (int i = 0; i < extra; i++) begin
            wr_byte(8'($urandom), a);
            chk(!a, "R5", a, 0);
        end
        bus_stop();
        chk(bad == 0, "R3", bad, 0);
        chk(sptr == exp_ptr, "R3", sptr, exp_ptr);
        for (int i = 1; i <= n + extra; i++) begin
            chk(mem[8'(exp_ptr - 8'(i))] == exp_mem[8'(exp_ptr - 8'(i))], "R3",
                mem[8'(exp_ptr - 8'(i))], exp_mem[8'(exp_ptr - 8'(i))]);
        end
    endtask

    // Block read of k data bytes; nack_last NACKs the k-th, else all ACKed.
    task automatic blk_read(input int k, input bit nack_last, input string tag);
        logic a;
        logic [7:0] b;
        int bad = 0;
        bus_start();
        wr_byte({DEV, 1'b0}, a); if (!a) bad++;
        wr_byte(8'h84, a);       if (!a) bad++;
        bus_start();
        wr_byte({DEV, 1'b1}, a); if (!a) bad++;
        rd_byte(b, 1'b1);
        chk(b == 8'h10, "R7", b, 8'h10);
        for (int i = 0; i < k; i++) begin
            rd_byte(b, !(nack_last && i == k - 1));
            chk(b == exp_mem[exp_ptr], tag, b, exp_mem[exp_ptr]);
            exp_ptr = exp_ptr + 8'd1;
        end
        rd_byte(b, 1'b0);
        chk(b == 8'hFF, "R8", b, 8'hFF);
        bus_stop();
        chk(bad == 0, tag, bad, 0);
        chk(sptr == exp_ptr, tag, sptr, exp_ptr);
        chk(sda_oe == 1'b0, "R8", sda_oe, 0);
    endtask

    initial begin
        logic a;
        logic [7:0] b;
        logic [7:0] snap;
        void'($urandom(32'h5EED));
        for (int i = 0; i < 256; i++) exp_mem[i] = init_val(i);
        exp_ptr = 8'h00;
        rst_n = 1'b0; scl = 1'b1; m_sda = 1'b1; busy = 1'b0;
        repeat (6) @(negedge clk);
        chk(sda_oe == 0 && wr_stb == 0 && ptr_load == 0 && ptr_inc == 0, "R1",
            {sda_oe, wr_stb, ptr_load, ptr_inc}, 0);
        rst_n = 1'b1;
        repeat (4) @(negedge clk);
        chk(sda_oe == 0 && wr_stb == 0 && ptr_inc == 0, "R1",
            {sda_oe, wr_stb, ptr_inc}, 0);

        // R2: valid, boundary and out-of-range pointer commands.
        set_ptr(8'h10, 1'b1);
        set_ptr(8'h60, 1'b0);
        set_ptr(8'h45, 1'b1);
        set_ptr(8'h08, 1'b1);

        // R3: block writes of the boundary counts.
        blk_write(16, 0);
        set_ptr(8'h20, 1'b1);
        blk_write(1, 0);

        // R4: bad counts 0 and 17 are refused and write nothing.
        for (int c = 0; c < 2; c++) begin
            snap = mem[exp_ptr];
            bus_start();
            wr_byte({DEV, 1'b0}, a);
            wr_byte(8'h83, a);
            wr_byte(c == 0 ? 8'd0 : 8'd17, a); chk(!a, "R4", a, 0);
            wr_byte(8'hA5, a);                 chk(!a, "R4", a, 0);
            bus_stop();
            chk(mem[exp_ptr] == snap && sptr == exp_ptr, "R4", mem[exp_ptr], snap);
        end

        // R5: bytes beyond the announced count.
        blk_write(3, 2);

        // R6: receive byte, single and two with master ACK.
        set_ptr(8'h12, 1'b1);
        bus_start();
        wr_byte({DEV, 1'b1}, a); chk(a, "R6", a, 1);
        rd_byte(b, 1'b0);
        bus_stop();
        chk(b == exp_mem[exp_ptr], "R6", b, exp_mem[exp_ptr]);
        exp_ptr = exp_ptr + 8'd1;
        chk(sptr == exp_ptr, "R6", sptr, exp_ptr);
        bus_start();
        wr_byte({DEV, 1'b1}, a);
        rd_byte(b, 1'b1);
        chk(b == exp_mem[exp_ptr], "R6", b, exp_mem[exp_ptr]);
        exp_ptr = exp_ptr + 8'd1;
        rd_byte(b, 1'b0);
        chk(b == exp_mem[exp_ptr], "R6", b, exp_mem[exp_ptr]);
        exp_ptr = exp_ptr + 8'd1;
        bus_stop();
        chk(sptr == exp_ptr, "R6", sptr, exp_ptr);

        // R7: full block read; R8: early NACK after three bytes.
        set_ptr(8'h08, 1'b1);
        blk_read(16, 1'b0, "R7");
        set_ptr(8'h04, 1'b1);
        blk_read(3, 1'b1, "R8");

        // R9: busy withholds ACK of 84h; the read is a receive byte.
        set_ptr(8'h30, 1'b1);
        busy = 1'b1;
        bus_start();
        wr_byte({DEV, 1'b0}, a);
        wr_byte(8'h84, a); chk(!a, "R9", a, 0);
        busy = 1'b0;
        bus_start();
        wr_byte({DEV, 1'b1}, a);
        rd_byte(b, 1'b0);
        bus_stop();
        chk(b == exp_mem[exp_ptr], "R9", b, exp_mem[exp_ptr]);
        exp_ptr = exp_ptr + 8'd1;

        // R12: STOP disarms a block read.
        bus_start();
        wr_byte({DEV, 1'b0}, a);
        wr_byte(8'h84, a); chk(a, "R12", a, 1);
        bus_stop();
        bus_start();
        wr_byte({DEV, 1'b1}, a);
        rd_byte(b, 1'b0);
        bus_stop();
        chk(b == exp_mem[exp_ptr], "R12", b, exp_mem[exp_ptr]);
        exp_ptr = exp_ptr + 8'd1;

        // R10: foreign addresses, write and read, never driven.
        watch = 1'b1;
        bus_start();
        wr_byte({7'h11, 1'b0}, a); chk(!a, "R10", a, 0);
        wr_byte(8'h83, a);         chk(!a, "R10", a, 0);
        wr_byte(8'h02, a);
        wr_byte(8'h5A, a);
        bus_stop();
        bus_start();
        wr_byte({7'h53, 1'b1}, a); chk(!a, "R10", a, 0);
        rd_byte(b, 1'b0);          chk(b == 8'hFF, "R10", b, 8'hFF);
        bus_stop();
        watch = 1'b0;
        chk(drove == 0, "R10", drove, 0);
        chk(sptr == exp_ptr, "R10", sptr, exp_ptr);

        // R11: STOP in the middle of a data byte, then START in the middle.
        snap = mem[exp_ptr];
        bus_start();
        wr_byte({DEV, 1'b0}, a);
        wr_byte(8'h83, a);
        wr_byte(8'd2, a);
        for (int i = 0; i < 4; i++) bus_bit(1'b0, a);
        bus_stop();
        chk(mem[exp_ptr] == snap && sptr == exp_ptr, "R11", mem[exp_ptr], snap);
        bus_start();
        wr_byte({DEV, 1'b0}, a);
        for (int i = 0; i < 3; i++) bus_bit(1'b0, a);
        bus_start();
        wr_byte({DEV, 1'b1}, a); chk(a, "R11", a, 1);
        rd_byte(b, 1'b0);
        bus_stop();
        chk(b == exp_mem[exp_ptr], "R11", b, exp_mem[exp_ptr]);
        exp_ptr = exp_ptr + 8'd1;

        // Random write-then-read-back rounds.
        for (int it = 0; it < 5; it++) begin
            logic [7:0] p;
            int n;
            p = 8'($urandom_range(0, 8'h30));
            n = int'($urandom_range(1, 16));
            set_ptr(p, 1'b1);
            blk_write(n, 0);
            set_ptr(p, 1'b1);
            blk_read(n, 1'b1, "R7");
        end

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            vecs++;
            errs++;
            $display("FAIL watchdog actual=%0h expected=%0h", 0, 1);
            $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
            $finish;
        end
    end

endmodule